// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Status

This unit adds or subtracts two 64-bit integers and records whether the operation overflowed. The operation select chooses addition or subtraction and whether overflow is judged under unsigned or signed (two's complement) rules. A width select lets the same datapath run 32-bit word operations: only the low halves of the operands are used, and the result is the sign-extended 32-bit value.

Two status bits are kept. The first shows whether the most recent accepted operation overflowed. The second is sticky. Any overflow sets it, and it stays set until a clear strobe arrives. Software can run a long sequence of arithmetic and test this bit once at the end, instead of testing after every operation. Overflow never raises an exception or trap. It only changes the status bits. The status bits reach the outputs only while the read strobe is high.

Top module: `ovf_adder_unit`

## Requirements
- R1: While reset is low and after its release, the result register and both status bits read zero.
- R2: A doubleword operation accepted with `op_valid` high gives `res` equal to a+b or a−b modulo 2^64, visible one clock after the accepting edge. `op_sel[0]`=1 selects subtract.
- R3: With `op_sel[1]`=0 (unsigned rule), an add overflows when the true sum needs a carry out of the top bit. A subtract overflows when the first operand is smaller than the second (borrow).
- R4: With `op_sel[1]`=1 (signed rule), an add or subtract overflows when the exact two's complement result lies outside the signed range of the operation width.
- R5: With `word_mode`=1, only bits 31:0 of each operand are used and `res` is the sign-extension of the low 32 bits of the outcome. Overflow is judged on the 32-bit range: signed for `op_sel[1]`=1, a 33rd-bit carry or borrow for `op_sel[1]`=0.
- R6: The last-operation bit is rewritten by every accepted operation with that operation's overflow, including a clean operation, which writes 0.
- R7: The sticky bit is set by any accepted overflowing operation. It stays set through later clean operations.
- R8: A `clr_sticky` pulse clears the sticky bit. When it coincides with an accepted overflowing operation, the sticky bit is 1 afterwards.
- R9: A cycle with `op_valid` low changes neither `res` nor the last-operation bit, and it can change the sticky bit only through `clr_sticky`.
- R10: `flag_last` and `flag_sticky` read 0 while `rd_flags` is low. While it is high they show the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept the operation presented this cycle |
| op_sel | input | 2 | Bit 0: subtract; bit 1: signed overflow rule |
| word_mode | input | 1 | 1: 32-bit word operation, 0: 64-bit |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| clr_sticky | input | 1 | Clear the sticky overflow bit |
| rd_flags | input | 1 | Drive the status bits onto the flag outputs |
| res | output | 64 | Registered result |
| flag_last | output | 1 | Overflow of the most recent operation (gated by rd_flags) |
| flag_sticky | output | 1 | Accumulated overflow since the last clear (gated by rd_flags) |

## Verification
The hardest case to reach from the ports is a clear strobe that lands on the same edge as an overflowing operation. That event must leave the sticky bit set. A clear on the same edge as a clean operation must leave it cleared. The stimulus builds this case on purpose. It first sets the sticky bit, then applies a clear alone, a clear with a clean operation, and a clear with an overflowing one. Operand values sit exactly at the carry, borrow and signed range limits in both widths, so a rule that is off by one bit changes a flag.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

  typedef enum logic [1:0] {
    OP_ADD_U = 2'b00,
    OP_SUB_U = 2'b01,
    OP_ADD_S = 2'b10,
    OP_SUB_S = 2'b11
  } op_e;

  function automatic logic op_is_sub(input op_e op);
    return op == OP_SUB_U || op == OP_SUB_S;
  endfunction

  function automatic logic op_is_signed(input op_e op);
    return op == OP_ADD_S || op == OP_SUB_S;
  endfunction

endpackage

// File: rtl/ovf_addsub.sv
module ovf_addsub #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              do_sub,
  input  logic              word,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_u,
  output logic              ovf_s
);
  localparam int MSB   = DATA_W - 1;
  localparam int WMSB  = WORD_W - 1;
  localparam int EXT_W = DATA_W - WORD_W;

  function automatic logic [DATA_W-1:0] sext_w(input logic [DATA_W-1:0] v);
    return {{EXT_W{v[WMSB]}}, v[WMSB:0]};
  endfunction

  function automatic logic [DATA_W-1:0] zext_w(input logic [DATA_W-1:0] v);
    return {{EXT_W{1'b0}}, v[WMSB:0]};
  endfunction

  // unsigned add wraps exactly when the truncated sum drops below a
  function automatic logic add_uovf(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] s);
    return s < x;
  endfunction

  // signed add: (s < x signed) must agree with (y negative)
  function automatic logic add_sovf(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                    input logic [DATA_W-1:0] s);
    return ($signed(s) < $signed(x)) != y[MSB];
  endfunction

  function automatic logic sub_uovf(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  // signed sub: operands of different sign and result sign flipped from x
  function automatic logic sub_sovf(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
                                    input logic [DATA_W-1:0] s);
    return (x[MSB] != y[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  logic [DATA_W-1:0] dw_sum;
  logic [DATA_W-1:0] ws_a, ws_b, ws_sum;
  logic [DATA_W-1:0] wz_a, wz_b, wz_sum;
  logic              dw_u, dw_s, w_u, w_s;

  always_comb begin
    dw_sum = do_sub ? (a - b) : (a + b);
    dw_u   = do_sub ? sub_uovf(a, b) : add_uovf(a, dw_sum);
    dw_s   = do_sub ? sub_sovf(a, b, dw_sum) : add_sovf(a, b, dw_sum);

    ws_a   = sext_w(a);
    ws_b   = sext_w(b);
    ws_sum = do_sub ? (ws_a - ws_b) : (ws_a + ws_b);
    // word signed: full-width outcome disagrees with its own sign-extended low half
    w_s    = ws_sum != sext_w(ws_sum);

    wz_a   = zext_w(a);
    wz_b   = zext_w(b);
    wz_sum = do_sub ? (wz_a - wz_b) : (wz_a + wz_b);
    w_u    = wz_sum[WORD_W];

    sum    = word ? sext_w(dw_sum) : dw_sum;
    ovf_u  = word ? w_u : dw_u;
    ovf_s  = word ? w_s : dw_s;
  end

endmodule

// File: rtl/ovf_pick.sv
module ovf_pick (
  input  ovf_pkg::op_e op,
  input  logic         ovf_u,
  input  logic         ovf_s,
  output logic         ovf_now
);
  always_comb ovf_now = ovf_pkg::op_is_signed(op) ? ovf_s : ovf_u;
endmodule

// File: rtl/ovf_flags.sv
module ovf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic ovf_now,
  input  logic clr,
  output logic last_q,
  output logic sticky_q
);
  logic set_evt;
  assign set_evt = take & ovf_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (take) last_q <= ovf_now;
      if (set_evt)  sticky_q <= 1'b1;
      else if (clr) sticky_q <= 1'b0;
    end
  end

  AST_LAST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> last_q == $past(ovf_now)); // R6
  AST_LAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(last_q)); // R9
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ovf_now) |=> sticky_q); // R7
  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(take && ovf_now)) |=> !sticky_q); // R8
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sticky_q) |=> sticky_q); // R7

endmodule

// File: rtl/ovf_adder_unit.sv
module ovf_adder_unit #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              clr_sticky,
  input  logic              rd_flags,
  output logic [DATA_W-1:0] res,
  output logic              flag_last,
  output logic              flag_sticky
);
  import ovf_pkg::*;

  localparam int WMSB = WORD_W - 1;

  op_e               op;
  logic [DATA_W-1:0] sum_w;
  logic              raw_u, raw_s, ovf_now;
  logic              last_q, sticky_q;
  logic [DATA_W-1:0] res_q;

  assign op = op_e'(op_sel);

  ovf_addsub #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_dp (
    .a(opnd_a), .b(opnd_b), .do_sub(op_is_sub(op)), .word(word_mode),
    .sum(sum_w), .ovf_u(raw_u), .ovf_s(raw_s)
  );

  ovf_pick u_pick (.op(op), .ovf_u(raw_u), .ovf_s(raw_s), .ovf_now(ovf_now));

  ovf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .take(op_valid), .ovf_now(ovf_now),
    .clr(clr_sticky), .last_q(last_q), .sticky_q(sticky_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (op_valid) res_q <= sum_w;
  end

  assign res         = res_q;
  assign flag_last   = rd_flags & last_q;
  assign flag_sticky = rd_flags & sticky_q;

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res)); // R9
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && word_mode) |=> res[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){res[WMSB]}}); // R5
  AST_FLAG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_flags |-> !flag_last && !flag_sticky); // R10

endmodule

// File: tb/sim_ovf_adder_unit.sv
`timescale 1ns/1ps
module sim_ovf_adder_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        word_mode = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        clr_sticky = 1'b0;
  logic        rd_flags = 1'b1;
  logic [63:0] res;
  logic        flag_last, flag_sticky;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  logic [63:0] m_res = '0;
  logic        m_last = 1'b0;
  logic        m_sticky = 1'b0;

  always #2.5 clk = ~clk;

  ovf_adder_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .clr_sticky(clr_sticky), .rd_flags(rd_flags), .res(res),
    .flag_last(flag_last), .flag_sticky(flag_sticky)
  );

  // exact integer arithmetic on widened values, then range test
  task automatic model_op(input logic sub, input logic sgn, input logic w,
                          input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] r, output logic ov);
    logic signed [65:0] xa, xb, xr;
    longint lo, hi;
    if (w) begin
      if (sgn) begin
        xa = 66'(signed'(a[31:0])); xb = 66'(signed'(b[31:0]));
      end else begin
        xa = {34'd0, a[31:0]}; xb = {34'd0, b[31:0]};
      end
      lo = sgn ? -64'sd2147483648 : 0;
      hi = sgn ?  64'sd2147483647 : 64'sd4294967295;
    end else begin
      if (sgn) begin
        xa = {{2{a[63]}}, a}; xb = {{2{b[63]}}, b};
      end else begin
        xa = {2'b00, a}; xb = {2'b00, b};
      end
      lo = 0; hi = 0;
    end
    xr = sub ? xa - xb : xa + xb;
    if (w) begin
      ov = (xr < 66'(lo)) || (xr > 66'(hi));
      r  = {{32{xr[31]}}, xr[31:0]};
    end else begin
      if (sgn) ov = (xr < -(66'sd1 <<< 63)) || (xr > ((66'sd1 <<< 63) - 1));
      else     ov = (xr < 0) || (xr > ((66'sd1 <<< 64) - 1));
      r = xr[63:0];
    end
  endtask

  task automatic compare(input string tag);
    logic el, es;
    el = rd_flags & m_last;
    es = rd_flags & m_sticky;
    total++;
    if (res !== m_res) begin
      bad++;
      $display("FAIL %s res actual=%h expected=%h", tag, res, m_res);
    end
    total++;
    if (flag_last !== el) begin
      bad++;
      $display("FAIL %s flag_last actual=%b expected=%b", tag, flag_last, el);
    end
    total++;
    if (flag_sticky !== es) begin
      bad++;
      $display("FAIL %s flag_sticky actual=%b expected=%b", tag, flag_sticky, es);
    end
  endtask

  // one cycle: drive after falling edge, model the rising edge, check after it
  task automatic step(input string tag, input logic v, input logic [1:0] op, input logic w,
                      input logic [63:0] a, input logic [63:0] b,
                      input logic clr, input logic rd);
    logic [63:0] r;
    logic ov;
    @(negedge clk);
    op_valid = v; op_sel = op; word_mode = w; opnd_a = a; opnd_b = b;
    clr_sticky = clr; rd_flags = rd;
    model_op(op[0], op[1], w, a, b, r, ov);
    @(posedge clk);
    if (v) begin
      m_res  = r;
      m_last = ov;
    end
    if (v && ov) m_sticky = 1'b1;
    else if (clr) m_sticky = 1'b0;
    #1;
    compare(tag);
  endtask

  localparam logic [63:0] UMAX = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;

  initial begin
    // R1: reset state
    #1;
    compare("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1");

    // R2: plain doubleword results, no overflow expected in most
    step("R2", 1, 2'b00, 0, 64'd5, 64'd7, 0, 1);
    step("R2", 1, 2'b01, 0, 64'd100, 64'd1, 0, 1);
    step("R2", 1, 2'b10, 0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0, 1);
    for (int i = 0; i < 40; i++)
      step("R2", 1, 2'($urandom), 0, {$urandom, $urandom}, {$urandom, $urandom}, 0, 1);

    // R3: unsigned carry and borrow limits
    step("R3", 1, 2'b00, 0, UMAX, 64'd1, 0, 1);
    step("R3", 1, 2'b00, 0, UMAX, 64'd0, 0, 1);
    step("R3", 1, 2'b00, 0, SMIN, SMIN, 0, 1);
    step("R3", 1, 2'b01, 0, 64'd0, 64'd1, 0, 1);
    step("R3", 1, 2'b01, 0, 64'd9, 64'd9, 0, 1);

    // R4: signed range limits
    step("R4", 1, 2'b10, 0, SMAX, 64'd1, 0, 1);
    step("R4", 1, 2'b10, 0, SMIN, UMAX, 0, 1);
    step("R4", 1, 2'b10, 0, SMAX, UMAX, 0, 1);
    step("R4", 1, 2'b11, 0, SMIN, 64'd1, 0, 1);
    step("R4", 1, 2'b11, 0, SMAX, UMAX, 0, 1);
    step("R4", 1, 2'b11, 0, UMAX, SMAX, 0, 1);

    // R5: word operations, upper operand bits carry junk
    step("R5", 1, 2'b10, 1, 64'hDEAD_0000_7FFF_FFFF, 64'hBEEF_0000_0000_0001, 0, 1);
    step("R5", 1, 2'b10, 1, 64'h0000_0000_7FFF_FFFE, 64'h0000_0000_0000_0001, 0, 1);
    step("R5", 1, 2'b11, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 0, 1);
    step("R5", 1, 2'b00, 1, 64'h1111_1111_FFFF_FFFF, 64'd1, 0, 1);
    step("R5", 1, 2'b01, 1, 64'hFFFF_FFFF_0000_0000, 64'd1, 0, 1);
    step("R5", 1, 2'b00, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 0, 1);
    for (int i = 0; i < 40; i++)
      step("R5", 1, 2'($urandom), 1, {$urandom, $urandom}, {$urandom, $urandom}, 0, 1);

    // R6: last flag overwritten, clean op writes zero
    step("R6", 1, 2'b00, 0, UMAX, 64'd2, 0, 1);
    step("R6", 1, 2'b00, 0, 64'd2, 64'd2, 0, 1);

    // R7: sticky survives clean ops
    step("R7", 1, 2'b00, 0, 64'd3, 64'd4, 0, 1);
    step("R7", 1, 2'b10, 0, 64'd3, 64'd4, 0, 1);

    // R8: clear alone, clear with clean op, clear with overflowing op
    step("R8", 0, 2'b00, 0, 64'd0, 64'd0, 1, 1);
    step("R8", 1, 2'b10, 0, SMAX, 64'd1, 0, 1);
    step("R8", 1, 2'b00, 0, 64'd1, 64'd1, 1, 1);
    step("R8", 1, 2'b10, 0, SMAX, 64'd1, 0, 1);
    step("R8", 1, 2'b10, 0, SMAX, 64'd1, 1, 1);
    step("R8", 0, 2'b00, 0, 64'd0, 64'd0, 0, 1);

    // R9: idle cycles with overflowing operands leave state untouched
    step("R9", 1, 2'b00, 0, 64'd10, 64'd20, 1, 1);
    step("R9", 0, 2'b00, 0, UMAX, UMAX, 0, 1);
    step("R9", 0, 2'b11, 1, SMIN, SMAX, 0, 1);

    // R10: flags gated by read strobe
    step("R10", 1, 2'b00, 0, UMAX, UMAX, 0, 0);
    step("R10", 0, 2'b00, 0, 64'd0, 64'd0, 0, 0);
    step("R10", 0, 2'b00, 0, 64'd0, 64'd0, 0, 1);

    // mixed random stream with occasional clears and reads
    for (int i = 0; i < 200; i++)
      step("R7", 1'($urandom), 2'($urandom), 1'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom},
           ($urandom % 8) == 0, ($urandom % 4) != 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule